// File: doc/BRIEF.md
# Receive Reset Sequencer

This block brings a multi-gigabit serial receiver out of reset in a fixed order. It runs on a free-running stable clock. First it holds the PLL reset and the receiver reset for a minimum time. It then waits for PLL lock and releases the receiver reset. An internal counter, cleared while the receiver is in reset, decides when the recovered clock counts as stable. The block then raises receiver user-ready and waits for the receiver's reset-done indication. When the receive elastic buffer is bypassed, it also issues a phase-alignment start pulse and waits for alignment-done. Next it requires data-valid to stay high without a break for a full window (about 100 us at default settings). It waits a further short settle time (about 1 us) and then raises its done flag.

The done flag is also passed through a reset synchroniser into the receive user-clock domain, so that logic there can use it as a reset. All waits are given in nanoseconds and converted to stable-clock cycles from a clock-period parameter, which lets a simulation shorten them. If PLL lock is lost, the reference clock is reported lost, or any wait runs past a timeout, the sequencer returns to its first step and increments a saturating retry counter. Parameters choose three things: whether the user clock comes from the transmit side (user-ready then waits for the transmit user-ready flag), whether the elastic buffer is bypassed, and whether the transmit side drives the shared PLL reset.

Top module: `rxrst_seq`

## Requirements
- R1: After reset the block holds PLL reset and receiver reset high, with user-ready, alignment start and done low and the retry count at 0. The hold step lasts HOLD_CYCLES stable-clock cycles.
- R2: After the hold step the PLL reset is released. The receiver reset stays high until pll_lock is seen high, and it is released on the next cycle.
- R3: The recovered-clock-stable flag is set by a counter that clears while the receiver reset is high. The flag goes high lock-wait cycles after the reset is released. With the transmit gate open, user-ready then rises exactly lock-wait + 2 cycles after the receiver reset falls.
- R4: When USRCLK_FROM_TX is 1, user-ready rises only in the cycle after tx_user_rdy has been seen high. When it is 0, tx_user_rdy has no effect.
- R5: After user-ready rises, the sequence does not advance until rx_rst_done is high.
- R6: With BUF_BYPASS = 1, align_start is a single-cycle pulse on entry to the alignment step, and the step ends when align_done is high. With BUF_BYPASS = 0 no pulse is issued and the step is skipped.
- R7: data_valid must be high for the valid-window count of consecutive cycles. A low cycle restarts the count.
- R8: After the valid window the block waits the settle count of cycles and then holds done high.
- R9: refclk_lost high in any step other than hold, or pll_lock low in any step after the lock wait, sends the block back to the hold step and adds one to the retry count.
- R10: A wait step (lock, clock-stable, transmit-ready, reset-done, alignment, valid window) that lasts the timeout count of cycles without completing returns the block to the hold step and adds one to the retry count.
- R11: The retry count saturates at its all-ones value.
- R12: usr_ready clears at once when done falls. It rises only after SYNC_STAGES rising edges of usr_clk with done high.
- R13: When PLL_SHARED_TX is 1, pll_rst follows tx_pll_rst. Otherwise the sequencer drives pll_rst high only during the hold step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running stable clock |
| rst | input | 1 | Synchronous active-high reset |
| usr_clk | input | 1 | Receive user clock |
| pll_lock | input | 1 | PLL lock indication |
| refclk_lost | input | 1 | Reference clock lost indication |
| rx_rst_done | input | 1 | Receiver reset complete |
| align_done | input | 1 | Phase alignment complete |
| data_valid | input | 1 | Receive data judged valid |
| tx_user_rdy | input | 1 | Transmit side user-ready flag |
| tx_pll_rst | input | 1 | PLL reset from the transmit sequencer |
| pll_rst | output | 1 | PLL reset |
| rx_rst | output | 1 | Receiver reset |
| user_rdy | output | 1 | Receiver user-ready |
| align_start | output | 1 | Phase alignment start pulse |
| retry_cnt | output | RETRY_W | Saturating retry count |
| done | output | 1 | Sequence complete (stable-clock domain) |
| usr_ready | output | 1 | Done flag synchronised to usr_clk |

## Verification
Two configurations run in parallel against the same stimulus: one with a bypassed buffer, a transmit-gated user clock and its own PLL reset, and one with an active buffer, no gate and a shared PLL reset. The first pass holds tx_user_rdy low, which separates the gated configuration from the ungated one. A single-cycle drop in data_valid shows whether the valid window restarts or only pauses. A reference-clock-lost pulse and a lock loss check the recovery path and the asynchronous clear of usr_ready. A held-low lock then drives repeated timeouts, which tells a correct saturating retry count from one that wraps or stops early.

// File: rtl/rxrst_pkg.sv
package rxrst_pkg;

   typedef enum logic [3:0] {
      ST_HOLD,
      ST_PLL,
      ST_STABLE,
      ST_URDY,
      ST_RDONE,
      ST_ALIGN,
      ST_VALID,
      ST_SETTLE,
      ST_DONE
   } rxrst_state_e;

   // Round a time in ns up to whole clock cycles (at least one).
   function automatic int unsigned ns_to_cyc(input longint unsigned ns,
                                             input longint unsigned period_ps);
      longint unsigned c;
      c = (ns * 64'd1000 + period_ps - 64'd1) / period_ps;
      if (c < 64'd1) c = 64'd1;
      return int'(c);
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rxrst_clkmon.sv
module rxrst_clkmon #(
   parameter int unsigned LOCK_CYC = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic hold_rst,
   output logic stable
);
   localparam int unsigned CW = $clog2(LOCK_CYC + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst || hold_rst) begin
         cnt    <= '0;
         stable <= 1'b0;
      end else if (!stable) begin
         if (cnt == CW'(LOCK_CYC - 1)) stable <= 1'b1;
         else                          cnt    <= cnt + 1'b1;
      end
   end

   // R3: an asserted receiver reset always clears the stable flag
   assert_stable_cleared_R3: assert property (@(posedge clk) disable iff (rst)
      hold_rst |=> !stable);

endmodule

// File: rtl/rxrst_rstsync.sv
module rxrst_rstsync #(
   parameter int unsigned STAGES = 2
) (
   input  logic usr_clk,
   input  logic arm,
   output logic ready
);
   logic [STAGES-1:0] shift;

   always_ff @(posedge usr_clk or negedge arm) begin
      if (!arm) shift <= '0;
      else      shift <= {shift[STAGES-2:0], 1'b1};
   end

   assign ready = shift[STAGES-1];

endmodule

// File: rtl/rxrst_seq.sv
module rxrst_seq
   import rxrst_pkg::*;
#(
   parameter int unsigned CLK_PERIOD_PS  = 4000,
   parameter int unsigned HOLD_CYCLES    = 8,
   parameter int unsigned LOCK_WAIT_NS   = 20000,
   parameter int unsigned VALID_WAIT_NS  = 100000,
   parameter int unsigned SETTLE_NS      = 1000,
   parameter int unsigned TIMEOUT_NS     = 1000000,
   parameter int unsigned RETRY_W        = 4,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter bit          BUF_BYPASS     = 1'b1,
   parameter bit          USRCLK_FROM_TX = 1'b1,
   parameter bit          PLL_SHARED_TX  = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               usr_clk,
   input  logic               pll_lock,
   input  logic               refclk_lost,
   input  logic               rx_rst_done,
   input  logic               align_done,
   input  logic               data_valid,
   input  logic               tx_user_rdy,
   input  logic               tx_pll_rst,
   output logic               pll_rst,
   output logic               rx_rst,
   output logic               user_rdy,
   output logic               align_start,
   output logic [RETRY_W-1:0] retry_cnt,
   output logic               done,
   output logic               usr_ready
);
   localparam int unsigned LOCK_CYC   = ns_to_cyc(LOCK_WAIT_NS, CLK_PERIOD_PS);
   localparam int unsigned VALID_CYC  = ns_to_cyc(VALID_WAIT_NS, CLK_PERIOD_PS);
   localparam int unsigned SETTLE_CYC = ns_to_cyc(SETTLE_NS, CLK_PERIOD_PS);
   localparam int unsigned TMO_CYC    = ns_to_cyc(TIMEOUT_NS, CLK_PERIOD_PS);
   localparam int unsigned DW_MAX     = umax(umax(HOLD_CYCLES, SETTLE_CYC), TMO_CYC);
   localparam int unsigned DW         = $clog2(DW_MAX + 1);
   localparam int unsigned VW         = $clog2(VALID_CYC + 1);
   localparam logic [RETRY_W-1:0] RMAX = '1;

   // elaboration-time parameter checks
   generate
      if (HOLD_CYCLES < 1) begin : g_bad_hold
         $error("HOLD_CYCLES must be at least 1");
      end
      if (TMO_CYC <= VALID_CYC + 1) begin : g_bad_tmo
         $error("timeout must exceed the data-valid window");
      end
      if (TMO_CYC <= LOCK_CYC + 1) begin : g_bad_lock
         $error("timeout must exceed the clock-stable wait");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (RETRY_W < 1) begin : g_bad_retry
         $error("RETRY_W must be at least 1");
      end
   endgenerate

   rxrst_state_e     state, nxt;
   logic [DW-1:0]    dwell;
   logic [VW-1:0]    vcnt;
   logic [RETRY_W-1:0] retry;
   logic             clk_ok, tx_ok, align_ok, own_pll_rst;
   logic             adv, fault, expired, waiting, go_retry;

   rxrst_clkmon #(.LOCK_CYC(LOCK_CYC)) u_clkmon (
      .clk      (clk),
      .rst      (rst),
      .hold_rst (rx_rst),
      .stable   (clk_ok)
   );

   generate
      if (USRCLK_FROM_TX) begin : g_txgate
         assign tx_ok = tx_user_rdy;
      end else begin : g_notxgate
         assign tx_ok = 1'b1;
      end
      if (BUF_BYPASS) begin : g_align
         assign align_ok = align_done;
      end else begin : g_noalign
         assign align_ok = 1'b1;
      end
      if (PLL_SHARED_TX) begin : g_pll_tx
         assign pll_rst = tx_pll_rst;
      end else begin : g_pll_own
         assign pll_rst = own_pll_rst;
      end
   endgenerate

   always_comb begin
      fault   = (state != ST_HOLD) &&
                (refclk_lost || ((state > ST_PLL) && !pll_lock));
      waiting = (state >= ST_PLL) && (state <= ST_VALID);
      expired = waiting && (dwell == DW'(TMO_CYC - 1));
      adv     = 1'b0;
      nxt     = state;
      unique case (state)
         ST_HOLD:   begin adv = (dwell == DW'(HOLD_CYCLES - 1)); nxt = ST_PLL; end
         ST_PLL:    begin adv = pll_lock;    nxt = ST_STABLE; end
         ST_STABLE: begin adv = clk_ok;      nxt = ST_URDY;   end
         ST_URDY:   begin adv = tx_ok;       nxt = ST_RDONE;  end
         ST_RDONE:  begin adv = rx_rst_done; nxt = BUF_BYPASS ? ST_ALIGN : ST_VALID; end
         ST_ALIGN:  begin adv = align_ok;    nxt = ST_VALID;  end
         ST_VALID:  begin adv = data_valid && (vcnt == VW'(VALID_CYC - 1)); nxt = ST_SETTLE; end
         ST_SETTLE: begin adv = (dwell == DW'(SETTLE_CYC - 1)); nxt = ST_DONE; end
         default:   begin adv = 1'b0;        nxt = ST_DONE;   end
      endcase
      go_retry = fault || (!adv && expired);
      if (go_retry)  nxt = ST_HOLD;
      else if (!adv) nxt = state;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_HOLD;
         dwell <= '0;
         vcnt  <= '0;
         retry <= '0;
      end else begin
         state <= nxt;
         if (nxt != state)           dwell <= '0;
         else if (dwell != DW'(DW_MAX)) dwell <= dwell + 1'b1;
         if (state == ST_VALID && data_valid && nxt == ST_VALID) vcnt <= vcnt + 1'b1;
         else                                                    vcnt <= '0;
         if (go_retry && retry != RMAX) retry <= retry + 1'b1;
      end
   end

   assign own_pll_rst = (state == ST_HOLD);
   assign rx_rst      = (state == ST_HOLD) || (state == ST_PLL);
   assign user_rdy    = (state >= ST_RDONE);
   assign align_start = (state == ST_ALIGN) && (dwell == '0);
   assign done        = (state == ST_DONE);
   assign retry_cnt   = retry;

   rxrst_rstsync #(.STAGES(SYNC_STAGES)) u_sync (
      .usr_clk (usr_clk),
      .arm     (done),
      .ready   (usr_ready)
   );

   // R2: receiver reset is released only after lock was observed
   assert_rx_release_after_lock_R2: assert property (@(posedge clk) disable iff (rst)
      (state == ST_STABLE && $past(state) == ST_PLL) |-> $past(pll_lock));

   // R4: user-ready rises only after the transmit side was ready
   assert_user_rdy_gated_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(user_rdy) |-> $past(tx_ok));

   // R5: leaving the reset-done wait forward needs reset-done
   assert_rdone_seen_R5: assert property (@(posedge clk) disable iff (rst)
      ($past(state) == ST_RDONE && state != ST_RDONE && !rx_rst) |-> $past(rx_rst_done));

   // R6: the alignment start is a one-cycle pulse
   assert_align_pulse_R6: assert property (@(posedge clk) disable iff (rst)
      align_start |=> !align_start);

   // R7: the valid window ends only on a valid cycle
   assert_valid_window_R7: assert property (@(posedge clk) disable iff (rst)
      (state == ST_SETTLE && $past(state) == ST_VALID) |-> $past(data_valid));

   // R9: a retry is always taken into the reset hold
   assert_retry_in_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (retry_cnt != $past(retry_cnt)) |-> (rx_rst && own_pll_rst));

   // R11: the retry count only steps up by one
   assert_retry_step_R11: assert property (@(posedge clk) disable iff (rst)
      (retry_cnt != $past(retry_cnt)) |-> (retry_cnt == $past(retry_cnt) + 1'b1));

endmodule

// File: tb/rxrst_seq_tb.sv
`timescale 1ns/1ps

// Behavioural reference of the sequence, written from the requirements.
module rxrst_ref #(
   parameter int HOLD = 4, parameter int LOCK = 6, parameter int VALID = 8,
   parameter int SETTLE = 3, parameter int TMO = 40, parameter int RMAX = 3,
   parameter bit BYPASS = 1, parameter bit FROM_TX = 1, parameter bit SHARED = 0
) (
   input  logic clk, rst, pll_lock, refclk_lost, rx_rst_done, align_done,
   input  logic data_valid, tx_user_rdy, tx_pll_rst,
   output logic pll_rst, rx_rst, user_rdy, align_start, done,
   output int   retry
);
   // phases: 0 hold,1 lock,2 clk stable,3 tx ready,4 reset done,5 align,6 valid,7 settle,8 done
   int ph = 0, dwell = 0, vrun = 0, since = 0;
   int rcount = 0;

   always @(posedge clk) begin
      int  nph;
      bit  prog, bad;
      if (rst) begin
         ph = 0; dwell = 0; vrun = 0; since = 0; rcount = 0;
      end else begin
         prog = 0;
         case (ph)
            0: prog = (dwell == HOLD - 1);
            1: prog = pll_lock;
            2: prog = (since >= LOCK);
            3: prog = FROM_TX ? tx_user_rdy : 1'b1;
            4: prog = rx_rst_done;
            5: prog = align_done;
            6: prog = data_valid && (vrun == VALID - 1);
            7: prog = (dwell == SETTLE - 1);
            default: prog = 0;
         endcase
         bad = (ph != 0) && (refclk_lost || (ph >= 2 && !pll_lock));
         if (!bad && !prog && ph >= 1 && ph <= 6 && dwell == TMO - 1) bad = 1;
         since = (ph <= 1) ? 0 : since + 1;
         if (since > 1000000) since = 1000000;
         if (bad) begin
            nph = 0;
            if (rcount < RMAX) rcount++;
         end else if (prog) nph = (ph == 4 && !BYPASS) ? 6 : ph + 1;
         else nph = ph;
         vrun  = (ph == 6 && data_valid && nph == 6) ? vrun + 1 : 0;
         dwell = (nph != ph) ? 0 : dwell + 1;
         ph    = nph;
      end
   end

   always_comb begin
      pll_rst     = SHARED ? tx_pll_rst : (ph == 0);
      rx_rst      = (ph <= 1);
      user_rdy    = (ph >= 4);
      align_start = (ph == 5) && (dwell == 0);
      done        = (ph == 8);
      retry       = rcount;
   end
endmodule

module rxrst_seq_tb;
   localparam real CLK_PERIOD = 10.0;
   localparam real USR_PERIOD = 7.0;
   localparam int  HOLD = 4, LOCK = 6, VALID = 8, SETTLE = 3, TMO = 40;

   logic clk = 0, usr_clk = 0, rst = 1;
   logic pll_lock = 0, refclk_lost = 0, rx_rst_done = 0, align_done = 0;
   logic data_valid = 0, tx_user_rdy = 0, tx_pll_rst = 0;

   logic a_pll, a_rx, a_ur, a_al, a_dn, a_usr;
   logic [1:0] a_rc;
   logic b_pll, b_rx, b_ur, b_al, b_dn, b_usr;
   logic [1:0] b_rc;
   logic ma_pll, ma_rx, ma_ur, ma_al, ma_dn;
   logic mb_pll, mb_rx, mb_ur, mb_al, mb_dn;
   int   ma_rc, mb_rc;

   int vectors = 0, fails = 0;
   int sidx = 0, fall_idx = -1, pulses_a = 0, pulses_b = 0;
   logic prev_b_rx = 1, prev_b_ur = 0, prev_a_dn = 0;

   always #(CLK_PERIOD/2) clk = ~clk;
   initial begin
      #1.3;
      forever #(USR_PERIOD/2) usr_clk = ~usr_clk;
   end

   rxrst_seq #(
      .CLK_PERIOD_PS(10000), .HOLD_CYCLES(HOLD), .LOCK_WAIT_NS(60),
      .VALID_WAIT_NS(80), .SETTLE_NS(30), .TIMEOUT_NS(400), .RETRY_W(2),
      .SYNC_STAGES(2), .BUF_BYPASS(1'b1), .USRCLK_FROM_TX(1'b1), .PLL_SHARED_TX(1'b0)
   ) u_dut (
      .clk(clk), .rst(rst), .usr_clk(usr_clk), .pll_lock(pll_lock),
      .refclk_lost(refclk_lost), .rx_rst_done(rx_rst_done), .align_done(align_done),
      .data_valid(data_valid), .tx_user_rdy(tx_user_rdy), .tx_pll_rst(tx_pll_rst),
      .pll_rst(a_pll), .rx_rst(a_rx), .user_rdy(a_ur), .align_start(a_al),
      .retry_cnt(a_rc), .done(a_dn), .usr_ready(a_usr)
   );

   rxrst_seq #(
      .CLK_PERIOD_PS(10000), .HOLD_CYCLES(HOLD), .LOCK_WAIT_NS(60),
      .VALID_WAIT_NS(80), .SETTLE_NS(30), .TIMEOUT_NS(400), .RETRY_W(2),
      .SYNC_STAGES(2), .BUF_BYPASS(1'b0), .USRCLK_FROM_TX(1'b0), .PLL_SHARED_TX(1'b1)
   ) u_alt (
      .clk(clk), .rst(rst), .usr_clk(usr_clk), .pll_lock(pll_lock),
      .refclk_lost(refclk_lost), .rx_rst_done(rx_rst_done), .align_done(align_done),
      .data_valid(data_valid), .tx_user_rdy(tx_user_rdy), .tx_pll_rst(tx_pll_rst),
      .pll_rst(b_pll), .rx_rst(b_rx), .user_rdy(b_ur), .align_start(b_al),
      .retry_cnt(b_rc), .done(b_dn), .usr_ready(b_usr)
   );

   rxrst_ref #(.HOLD(HOLD), .LOCK(LOCK), .VALID(VALID), .SETTLE(SETTLE), .TMO(TMO),
               .RMAX(3), .BYPASS(1), .FROM_TX(1), .SHARED(0)) u_ref_a (
      .clk(clk), .rst(rst), .pll_lock(pll_lock), .refclk_lost(refclk_lost),
      .rx_rst_done(rx_rst_done), .align_done(align_done), .data_valid(data_valid),
      .tx_user_rdy(tx_user_rdy), .tx_pll_rst(tx_pll_rst),
      .pll_rst(ma_pll), .rx_rst(ma_rx), .user_rdy(ma_ur), .align_start(ma_al),
      .done(ma_dn), .retry(ma_rc)
   );

   rxrst_ref #(.HOLD(HOLD), .LOCK(LOCK), .VALID(VALID), .SETTLE(SETTLE), .TMO(TMO),
               .RMAX(3), .BYPASS(0), .FROM_TX(0), .SHARED(1)) u_ref_b (
      .clk(clk), .rst(rst), .pll_lock(pll_lock), .refclk_lost(refclk_lost),
      .rx_rst_done(rx_rst_done), .align_done(align_done), .data_valid(data_valid),
      .tx_user_rdy(tx_user_rdy), .tx_pll_rst(tx_pll_rst),
      .pll_rst(mb_pll), .rx_rst(mb_rx), .user_rdy(mb_ur), .align_start(mb_al),
      .done(mb_dn), .retry(mb_rc)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   // per-cycle comparison against the reference, away from the clock edge
   always @(negedge clk) begin
      #2;
      if (!rst) begin
         sidx++;
         chk("R13", "main pll_rst",    a_pll, ma_pll);
         chk("R2",  "main rx_rst",     a_rx,  ma_rx);
         chk("R4",  "main user_rdy",   a_ur,  ma_ur);
         chk("R6",  "main align_start",a_al,  ma_al);
         chk("R8",  "main done",       a_dn,  ma_dn);
         chk("R9",  "main retry_cnt",  int'(a_rc), ma_rc);
         chk("R13", "alt pll_rst",     b_pll, mb_pll);
         chk("R2",  "alt rx_rst",      b_rx,  mb_rx);
         chk("R4",  "alt user_rdy",    b_ur,  mb_ur);
         chk("R6",  "alt align_start", b_al,  mb_al);
         chk("R8",  "alt done",        b_dn,  mb_dn);
         chk("R9",  "alt retry_cnt",   int'(b_rc), mb_rc);
         if (a_al) pulses_a++;
         if (b_al) pulses_b++;
         // R3: user-ready follows the receiver reset release by lock-wait + 2 cycles
         if (prev_b_rx && !b_rx) fall_idx = sidx;
         if (!prev_b_ur && b_ur && fall_idx >= 0)
            chk("R3", "alt release-to-user_rdy cycles", sidx - fall_idx, LOCK + 2);
         // R12: done just rose, synchroniser has not released yet
         if (!prev_a_dn && a_dn) chk("R12", "usr_ready at done rise", a_usr, 0);
         prev_b_rx = b_rx; prev_b_ur = b_ur; prev_a_dn = a_dn;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      finish_run();
   end

   initial begin
      cyc(3);
      rst = 0;
      #2;
      chk("R1", "pll_rst after reset", a_pll, 1);
      chk("R1", "rx_rst after reset", a_rx, 1);
      chk("R1", "user_rdy after reset", a_ur, 0);
      chk("R1", "done after reset", a_dn, 0);
      chk("R1", "retry after reset", int'(a_rc), 0);
      cyc(HOLD + 3); #2;
      chk("R2", "pll_rst released after hold", a_pll, 0);
      chk("R2", "rx_rst held without lock", a_rx, 1);
      tx_pll_rst = 1; #1;
      chk("R13", "shared pll_rst follows transmit", b_pll, 1);
      chk("R13", "owned pll_rst ignores transmit", a_pll, 0);
      tx_pll_rst = 0;
      pll_lock = 1;
      cyc(LOCK + 6); #2;
      chk("R4", "gated user_rdy while tx not ready", a_ur, 0);
      chk("R4", "ungated user_rdy", b_ur, 1);
      cyc(10); #2;
      chk("R4", "gated user_rdy still low", a_ur, 0);
      tx_user_rdy = 1;
      cyc(3); #2;
      chk("R4", "gated user_rdy after tx ready", a_ur, 1);
      cyc(5); #2;
      chk("R5", "no alignment before reset-done", pulses_a, 0);
      chk("R5", "no done before reset-done", a_dn, 0);
      rx_rst_done = 1;
      cyc(6);
      align_done = 1;
      cyc(2);
      data_valid = 1; cyc(4);
      data_valid = 0; cyc(1);
      data_valid = 1;
      cyc(VALID - 2); #2;
      chk("R7", "done held off by broken window", a_dn, 0);
      cyc(SETTLE + 8); #2;
      chk("R8", "main done", a_dn, 1);
      chk("R8", "alt done", b_dn, 1);
      chk("R12", "usr_ready after sync", a_usr, 1);
      chk("R6", "main alignment pulses", pulses_a, 1);
      chk("R6", "alt alignment pulses", pulses_b, 0);
      refclk_lost = 1; cyc(1); refclk_lost = 0; #2;
      chk("R9", "retry after refclk lost", int'(a_rc), 1);
      chk("R9", "done cleared by refclk lost", a_dn, 0);
      chk("R12", "usr_ready cleared at once", a_usr, 0);
      cyc(HOLD + LOCK + VALID + SETTLE + 20); #2;
      chk("R9", "done again after recovery", a_dn, 1);
      pll_lock = 0; cyc(1); #2;
      chk("R9", "retry after lock loss", int'(a_rc), 2);
      chk("R9", "rx_rst after lock loss", a_rx, 1);
      cyc(HOLD + TMO + 2); #2;
      chk("R10", "retry after lock timeout", int'(a_rc), 3);
      cyc(2 * (HOLD + TMO + 2)); #2;
      chk("R11", "retry saturated", int'(a_rc), 3);
      pll_lock = 1;
      cyc(HOLD + LOCK + VALID + SETTLE + 20); #2;
      chk("R8", "done after final recovery", a_dn, 1);
      chk("R11", "retry still saturated", int'(a_rc), 3);
      finish_run();
   end
endmodule